// File: doc/BRIEF.md
# Aligned Read Request Splitter

This block turns one device-to-host transfer descriptor into a series of read requests on a local memory-mapped read master. The descriptor carries a local start address, a total byte count of up to 1 MB, and a code that selects the maximum payload size. The block works out each request's address and byte count from these three values and presents them one at a time over a valid/ready handshake.

If the start address is not 64-byte aligned, the first request stops at the next 64-byte boundary. Every later request starts aligned. Each request after that carries one maximum payload, and the final request carries whatever remains. An aligned transfer that fits below the payload size goes out whole as one multi-beat read. When the last request is accepted, a one-cycle done pulse follows. The block then takes the next descriptor.

Top module: `read_splitter`

## Requirements
- R1: While reset is asserted and just after it is released, req_valid and xfer_done are low and desc_ready is high.
- R2: A descriptor is taken on a clock edge where desc_valid and desc_ready are both high. desc_ready stays low from that edge until the edge where the last request is accepted. Payload size code 0, 1, 2 and 3 selects 128, 256, 512 and 1024 bytes.
- R3: When the start address is not 64-byte aligned, the first request is at the start address. Its byte count is the smaller of the total and the distance to the next 64-byte boundary.
- R4: When the start address is 64-byte aligned and the total is a multiple of 64 below the payload size, exactly one request covering the whole total is issued.
- R5: When the start address is aligned and R4 does not apply, no boundary request is issued. The first request carries the smaller of the total and the payload size.
- R6: Every request after the first carries exactly the payload size, except the last, which carries the remaining byte count. The byte counts of all requests add up to the total.
- R7: While req_valid is high and req_ready is low, req_addr and req_len hold steady. After each accepted request, the next request's address equals the previous address plus the previous byte count.
- R8: xfer_done is high for exactly the one cycle after the edge where the last request is accepted. desc_ready is high in that cycle.
- R9: A descriptor with a byte count of zero produces no request. xfer_done is raised in the cycle after its acceptance.
- R10: A byte count of 1 MB (1048576) is split correctly. The payload size is latched at acceptance, so changes on desc_mps during a transfer have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor can be taken |
| desc_addr | input | ADDR_W | Local start address |
| desc_len | input | LEN_W | Total byte count (0 to 1048576) |
| desc_mps | input | 2 | Payload size code (128 << code bytes) |
| req_valid | output | 1 | Read request presented |
| req_ready | input | 1 | Read master accepts request |
| req_addr | output | ADDR_W | Request start address |
| req_len | output | LEN_W | Request byte count |
| xfer_done | output | 1 | One-cycle pulse after the last request is accepted |

## Verification
The bench targets start offsets just below a 64-byte boundary and totals smaller than the gap to that boundary. A design that got these wrong would issue a request crossing the boundary, or would add a spurious zero-length second request. It also feeds aligned totals equal to, just below and just above the payload size. These expose a fast-path test that wrongly uses "at or below", or one that skips a non-multiple-of-64 remainder. Under random back-pressure, the bench changes the payload code and the request inputs while a transfer is in flight. A design that re-reads desc_mps, or advances the address on an un-accepted request, would drift from the reference split. Zero-length and 1 MB descriptors check that done still fires exactly once and that the byte counter does not wrap.

// File: rtl/read_splitter.sv
module read_splitter #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 21,
  parameter int BND    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic [1:0]        desc_mps,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              xfer_done
);
  localparam int BW = $clog2(BND);

  logic              busy;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  rem;
  logic [1:0]        mps_q;
  logic              done_q;

  logic [LEN_W-1:0] mps_bytes, to_bnd, limit, chunk;
  logic [BW-1:0]    off;
  logic             take, fire, last;

  assign off       = cur_addr[BW-1:0];
  assign mps_bytes = LEN_W'(128) << mps_q;
  assign to_bnd    = LEN_W'(BND) - LEN_W'(off);
  assign limit     = (off != '0) ? to_bnd : mps_bytes;
  assign chunk     = (rem < limit) ? rem : limit;
  assign last      = (rem <= limit);

  assign desc_ready = !busy;
  assign req_valid  = busy;
  assign req_addr   = cur_addr;
  assign req_len    = chunk;
  assign xfer_done  = done_q;

  assign take = desc_valid && desc_ready;
  assign fire = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      rem      <= '0;
      mps_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        cur_addr <= desc_addr;
        rem      <= desc_len;
        mps_q    <= desc_mps;
        busy     <= (desc_len != '0);
        done_q   <= (desc_len == '0);
      end else if (fire) begin
        cur_addr <= cur_addr + ADDR_W'(chunk);
        rem      <= rem - chunk;
        if (last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !req_valid && !xfer_done && desc_ready);

  assert_no_desc_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !desc_ready);

  assert_len_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= mps_bytes));

  assert_hold_when_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len));

  assert_addr_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid || (req_addr == $past(req_addr) + ADDR_W'($past(req_len))));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !req_valid && desc_ready);

  assert_no_boundary_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_addr[BW-1:0] != '0) |-> (LEN_W'(req_addr[BW-1:0]) + req_len) <= LEN_W'(BND));
endmodule

// File: tb/read_splitter_bench.sv
module read_splitter_bench;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic desc_valid = 1'b0;
  logic desc_ready;
  logic [ADDR_W-1:0] desc_addr = '0;
  logic [LEN_W-1:0]  desc_len = '0;
  logic [1:0]        desc_mps = '0;
  logic req_valid;
  logic req_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic xfer_done;

  read_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BND(64)) u_read_splitter (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .desc_len(desc_len), .desc_mps(desc_mps),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .xfer_done(xfer_done)
  );

  always #4 clk = ~clk;

  typedef struct { longint unsigned a; longint unsigned l; string tag; } req_t;
  req_t q[$];
  bit exp_done = 0;
  string done_tag = "R8";
  int checks = 0;
  int errors = 0;
  bit stall_en = 1;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model: split a descriptor by the requirement rules
  task automatic build(input longint unsigned a0, input longint unsigned len, input int code);
    longint unsigned a = a0, r = len, c, m;
    bit first = 1;
    string t;
    m = 128 << code;
    while (r > 0) begin
      if (a % 64 != 0) begin
        c = (r < 64 - a % 64) ? r : 64 - a % 64; t = "R3";
      end else begin
        c = (r < m) ? r : m;
        t = !first ? "R6" : ((len % 64 == 0 && len < m) ? "R4" : "R5");
      end
      if (!first && a % 64 != 0) t = "R7";
      q.push_back('{a % (64'd1 << ADDR_W), c, t});
      a += c; r -= c; first = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); exp_done = 0;
    end else begin
      exp_done = 0;
      if (q.size() > 0 && req_ready) begin
        void'(q.pop_front());
        if (q.size() == 0) begin exp_done = 1; done_tag = "R8"; end
      end else if (q.size() == 0 && desc_valid) begin
        if (desc_len == 0) begin exp_done = 1; done_tag = "R9"; end
        else build(desc_addr, desc_len, desc_mps);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!req_valid && !xfer_done && desc_ready, "R1", "reset outputs",
          {req_valid, xfer_done, desc_ready}, 3'b001);
    end else begin
      chk(req_valid == (q.size() > 0), "R7", "req_valid", req_valid, q.size() > 0);
      chk(desc_ready == (q.size() == 0), "R2", "desc_ready", desc_ready, q.size() == 0);
      chk(xfer_done == exp_done, done_tag, "xfer_done", xfer_done, exp_done);
      if (q.size() > 0 && req_valid) begin
        chk(req_addr == q[0].a, q[0].tag, "req_addr", req_addr, q[0].a);
        chk(req_len == q[0].l, q[0].tag, "req_len", req_len, q[0].l);
      end
    end
    req_ready = stall_en ? ($urandom % 4 != 0) : 1'b1;
  end

  task automatic send(input longint unsigned a, input longint unsigned len, input int code);
    bit r;
    @(negedge clk);
    desc_valid = 1; desc_addr = ADDR_W'(a); desc_len = LEN_W'(len); desc_mps = 2'(code);
    do begin
      r = desc_ready;
      @(negedge clk);
    end while (!r);
    desc_valid = 0;
    while (!desc_ready) begin
      desc_mps = 2'($urandom);        // R10: must have no effect mid-transfer
      desc_addr = $urandom;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    send(32'h1000_003c, 2, 0);      // R3: shorter than gap, single request
    send(32'h1000_003c, 500, 0);    // R3 then R6
    send(32'h2000_0000, 192, 1);    // R4 aligned, multiple of 64, below 256
    send(32'h2000_0000, 256, 1);    // R5 equal to payload size
    send(32'h2000_0040, 300, 0);    // R5 aligned, not fast path
    send(32'h2000_0000, 64, 0);     // R4 single line
    send(32'h3000_0001, 63, 3);     // R3 exactly to boundary
    send(32'h3000_0001, 0, 2);      // R9 zero length
    send(32'h3000_0001, 0, 2);      // R9 back to back
    send(32'hffff_ffc0, 128, 0);    // R7 address wrap
    stall_en = 0;
    send(32'h4000_0010, 1048576, 3); // R10 full 1 MB
    stall_en = 1;
    send(32'h5000_0000, 1048576, 3); // R10 aligned 1 MB under stalls
    for (int i = 0; i < 60; i++)
      send($urandom, $urandom % 3000, $urandom % 4);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule